// File: doc/BRIEF.md
# PWM Channel Register Front End

This block is the register-facing side of a four-channel pulse-width modulator. A simple synchronous bus presents an address with separate write and read strobes. The block decodes that bus into a small global register set and a window of registers for each channel. The global set has a write-one-to-start register, a write-one-to-stop register, a read-only running status and a clear-on-read event register. Each channel window stores a mode word, the active duty and period counts, and the values queued for the next period. These stored values drive the external counter datapaths through flat output buses.

The channel datapaths pulse one event input per channel each time they begin a new period. The block latches these pulses until software reads the event register. That read clears every latched bit at once, except for a bit whose new event arrives in the same cycle. Read data is registered and returned one cycle after the read strobe.

The default register layout keeps separate queued-duty and queued-period registers. A parameter selects an alternative layout, where the period sits at +0x08 and a single queued-value register at +0x10 is steered by mode bit 10.

Top module: `pwm_rf_top`

## Requirements
- R1: Writing to offset 0x04 starts channel n for every bit n of the write data that is 1. Bits that are 0 leave their channel as it was.
- R2: Writing to offset 0x08 stops channel n for every bit n of the write data that is 1. Bits that are 0 leave their channel as it was.
- R3: A read of offset 0x0C returns the running state of channel n in bit n (bits [3:0]) with all higher bits zero. Writes to 0x0C change nothing. `ch_enable` carries the same bits.
- R4: A one-cycle pulse on `period_start[n]` sets bit n of the event register, which stays set through any number of idle cycles.
- R5: A read of offset 0x1C returns the event bits as they were before the read, then clears all of them together. An event pulse in the same cycle as that read is kept set afterwards.
- R6: Channel n's window begins at 0x200 + n*0x20. Its mode word at +0x00 keeps the low 11 bits of the write data, reads back zero-extended, and drives slice n of `ch_mode`.
- R7: In the default layout the duty count is at +0x04, the queued duty at +0x08, the period at +0x0C and the queued period at +0x10. Each keeps the low 16 bits, reads back zero-extended, and drives slice n of its output bus.
- R8: Reads of any unmapped offset return zero and writes to one leave every register unchanged. Unmapped offsets include 0x00, 0x10, a channel offset of +0x14, and addresses at or above 0x280.
- R9: Read data appears in the cycle after the read strobe. In a cycle that follows no read, `bus_rdata` is zero.
- R10: After reset, all channels are stopped, the event register is clear, and every channel register and `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (32) | Read data, one cycle after the strobe |
| period_start | input | NUM_CH (4) | Per-channel new-period pulse from datapaths |
| ch_enable | output | NUM_CH (4) | Running state per channel |
| ch_mode | output | NUM_CH*MODE_W (44) | Mode words, channel n at slice n |
| ch_duty | output | NUM_CH*CNT_W (64) | Active duty counts |
| ch_duty_nxt | output | NUM_CH*CNT_W (64) | Queued duty counts |
| ch_period | output | NUM_CH*CNT_W (64) | Active period counts |
| ch_period_nxt | output | NUM_CH*CNT_W (64) | Queued period counts |

## Verification
The start and stop registers are tested with sparse masks, all-zero masks and all-ones masks. These patterns show whether zero bits are really ignored and whether bits above the channel count leak into the status read. Channel registers are written with values wider than the stored field, in different channels and at different offsets. The readback then shows truncation, window stride and offset decode as separate faults. Event pulses are tested alone, held across idle cycles, and coinciding with the clearing read. This separates a latch that fails to hold, a clear that misses bits, and a clear that drops a coincident event.

// File: rtl/pwm_rf_pkg.sv
package pwm_rf_pkg;

   // global register byte offsets
   localparam int unsigned OFS_START  = 32'h004;
   localparam int unsigned OFS_STOP   = 32'h008;
   localparam int unsigned OFS_STATUS = 32'h00C;
   localparam int unsigned OFS_EVENT  = 32'h01C;

   // offsets inside a channel window
   localparam int unsigned CW_MODE = 32'h00;
   localparam int unsigned CW_DUTY = 32'h04;
   localparam int unsigned CW_Q10  = 32'h10;

   typedef struct packed {
      logic start;
      logic stop;
      logic status;
      logic event_r;
      logic chan;
   } rf_sel_t;

endpackage

// File: rtl/pwm_rf_decode.sv
module pwm_rf_decode
   import pwm_rf_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int NUM_CH    = 4,
   parameter int CH_BASE   = 32'h200,
   parameter int CH_STRIDE = 32'h20,
   localparam int IDX_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int OFF_W    = $clog2(CH_STRIDE)
) (
   input  logic [ADDR_W-1:0] addr,
   output rf_sel_t           sel,
   output logic [IDX_W-1:0]  ch_idx,
   output logic [OFF_W-1:0]  ch_off
);

   localparam logic [31:0] WIN_LO = 32'(CH_BASE);
   localparam logic [31:0] WIN_HI = 32'(CH_BASE + NUM_CH * CH_STRIDE);

   logic [31:0] a32;
   logic [31:0] rel;

   assign a32 = 32'(addr);
   assign rel = a32 - WIN_LO;

   always_comb begin
      sel         = '0;
      sel.start   = (a32 == OFS_START);
      sel.stop    = (a32 == OFS_STOP);
      sel.status  = (a32 == OFS_STATUS);
      sel.event_r = (a32 == OFS_EVENT);
      sel.chan    = (a32 >= WIN_LO) && (a32 < WIN_HI);
   end

   assign ch_idx = IDX_W'(rel >> OFF_W);
   assign ch_off = rel[OFF_W-1:0];

endmodule

// File: rtl/pwm_rf_glob.sv
module pwm_rf_glob #(
   parameter int NUM_CH = 4,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_wr,
   input  logic              stop_wr,
   input  logic              event_rd,
   input  logic [DATA_W-1:0] wdata,
   input  logic [NUM_CH-1:0] evt,
   output logic [NUM_CH-1:0] run,
   output logic [NUM_CH-1:0] irq
);

   logic [NUM_CH-1:0] mask;
   logic              unused_hi;

   assign mask      = wdata[NUM_CH-1:0];
   assign unused_hi = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run <= '0;
      end else if (start_wr) begin
         run <= run | mask;
      end else if (stop_wr) begin
         run <= run & ~mask;
      end
   end

   // a fresh event wins over the clearing read
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq <= '0;
      end else if (event_rd) begin
         irq <= evt;
      end else begin
         irq <= irq | evt;
      end
   end

endmodule

// File: rtl/pwm_rf_chan.sv
module pwm_rf_chan
   import pwm_rf_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 16,
   parameter int MODE_W   = 11,
   parameter int OFF_W    = 5,
   parameter bit DUAL_UPD = 1'b1,
   parameter int QSEL_BIT = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [OFF_W-1:0]  off,
   input  logic [DATA_W-1:0] wdata,
   output logic [MODE_W-1:0] mode,
   output logic [CNT_W-1:0]  duty,
   output logic [CNT_W-1:0]  duty_nxt,
   output logic [CNT_W-1:0]  per,
   output logic [CNT_W-1:0]  per_nxt,
   output logic [DATA_W-1:0] rd_val
);

   localparam int unsigned O_DQ  = DUAL_UPD ? 32'h08 : 32'h7FFF_FFFF;
   localparam int unsigned O_PER = DUAL_UPD ? 32'h0C : 32'h08;

   logic [31:0] o32;
   logic        unused_hi;

   assign o32       = 32'(off);
   assign unused_hi = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode <= '0;
         duty <= '0;
         per  <= '0;
      end else if (wr_en) begin
         if (o32 == CW_MODE) mode <= wdata[MODE_W-1:0];
         if (o32 == CW_DUTY) duty <= wdata[CNT_W-1:0];
         if (o32 == O_PER)   per  <= wdata[CNT_W-1:0];
      end
   end

   generate
      if (DUAL_UPD) begin : g_dual
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               duty_nxt <= '0;
               per_nxt  <= '0;
            end else if (wr_en) begin
               if (o32 == O_DQ)   duty_nxt <= wdata[CNT_W-1:0];
               if (o32 == CW_Q10) per_nxt  <= wdata[CNT_W-1:0];
            end
         end

         always_comb begin
            rd_val = '0;
            if (o32 == CW_MODE)     rd_val = DATA_W'(mode);
            else if (o32 == CW_DUTY) rd_val = DATA_W'(duty);
            else if (o32 == O_DQ)    rd_val = DATA_W'(duty_nxt);
            else if (o32 == O_PER)   rd_val = DATA_W'(per);
            else if (o32 == CW_Q10)  rd_val = DATA_W'(per_nxt);
         end
      end else begin : g_shared
         initial begin : chk_qsel
            assert (QSEL_BIT < MODE_W) else $error("queue select bit outside mode word");
         end

         logic to_per;
         assign to_per = mode[QSEL_BIT];

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               duty_nxt <= '0;
               per_nxt  <= '0;
            end else if (wr_en && (o32 == CW_Q10)) begin
               if (to_per) per_nxt  <= wdata[CNT_W-1:0];
               else        duty_nxt <= wdata[CNT_W-1:0];
            end
         end

         always_comb begin
            rd_val = '0;
            if (o32 == CW_MODE)      rd_val = DATA_W'(mode);
            else if (o32 == CW_DUTY) rd_val = DATA_W'(duty);
            else if (o32 == O_PER)   rd_val = DATA_W'(per);
            else if (o32 == CW_Q10)  rd_val = to_per ? DATA_W'(per_nxt) : DATA_W'(duty_nxt);
         end
      end
   endgenerate

endmodule

// File: rtl/pwm_rf_top.sv
module pwm_rf_top
   import pwm_rf_pkg::*;
#(
   parameter int NUM_CH    = 4,
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 16,
   parameter int MODE_W    = 11,
   parameter int CH_BASE   = 32'h200,
   parameter int CH_STRIDE = 32'h20,
   parameter bit DUAL_UPD  = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [DATA_W-1:0]        bus_wdata,
   input  logic                     bus_wr,
   input  logic                     bus_rd,
   output logic [DATA_W-1:0]        bus_rdata,
   input  logic [NUM_CH-1:0]        period_start,
   output logic [NUM_CH-1:0]        ch_enable,
   output logic [NUM_CH*MODE_W-1:0] ch_mode,
   output logic [NUM_CH*CNT_W-1:0]  ch_duty,
   output logic [NUM_CH*CNT_W-1:0]  ch_duty_nxt,
   output logic [NUM_CH*CNT_W-1:0]  ch_period,
   output logic [NUM_CH*CNT_W-1:0]  ch_period_nxt
);

   localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam int OFF_W = $clog2(CH_STRIDE);

   initial begin : elab_chk
      assert (NUM_CH >= 1 && NUM_CH <= DATA_W) else $error("NUM_CH out of range");
      assert (CNT_W <= DATA_W && MODE_W <= DATA_W) else $error("field wider than bus");
      assert ((1 << OFF_W) == CH_STRIDE) else $error("stride must be a power of two");
      assert (CH_STRIDE >= 32'h14) else $error("stride too small for window");
      assert (CH_BASE >= 32'h20) else $error("channel windows overlap globals");
      assert ((CH_BASE + NUM_CH * CH_STRIDE) <= (1 << ADDR_W)) else $error("address space too small");
   end

   rf_sel_t            sel;
   logic [IDX_W-1:0]   ch_idx;
   logic [OFF_W-1:0]   ch_off;
   logic [NUM_CH-1:0]  run_q;
   logic [NUM_CH-1:0]  irq_q;
   logic [DATA_W-1:0]  ch_rd [NUM_CH];
   logic [DATA_W-1:0]  rd_mux;

   pwm_rf_decode #(
      .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CH_BASE(CH_BASE), .CH_STRIDE(CH_STRIDE)
   ) u_dec (
      .addr(bus_addr), .sel(sel), .ch_idx(ch_idx), .ch_off(ch_off)
   );

   pwm_rf_glob #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_glob (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_wr (bus_wr & sel.start),
      .stop_wr  (bus_wr & sel.stop),
      .event_rd (bus_rd & sel.event_r),
      .wdata    (bus_wdata),
      .evt      (period_start),
      .run      (run_q),
      .irq      (irq_q)
   );

   generate
      for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
         logic wr_n;
         assign wr_n = bus_wr && sel.chan && (ch_idx == IDX_W'(n));

         pwm_rf_chan #(
            .DATA_W(DATA_W), .CNT_W(CNT_W), .MODE_W(MODE_W),
            .OFF_W(OFF_W), .DUAL_UPD(DUAL_UPD), .QSEL_BIT(10)
         ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_n),
            .off      (ch_off),
            .wdata    (bus_wdata),
            .mode     (ch_mode[n*MODE_W +: MODE_W]),
            .duty     (ch_duty[n*CNT_W +: CNT_W]),
            .duty_nxt (ch_duty_nxt[n*CNT_W +: CNT_W]),
            .per      (ch_period[n*CNT_W +: CNT_W]),
            .per_nxt  (ch_period_nxt[n*CNT_W +: CNT_W]),
            .rd_val   (ch_rd[n])
         );
      end
   endgenerate

   always_comb begin
      rd_mux = '0;
      if (sel.status)       rd_mux = DATA_W'(run_q);
      else if (sel.event_r) rd_mux = DATA_W'(irq_q);
      else if (sel.chan) begin
         for (int k = 0; k < NUM_CH; k++) begin
            if (ch_idx == IDX_W'(k)) rd_mux = ch_rd[k];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) bus_rdata <= '0;
      else        bus_rdata <= bus_rd ? rd_mux : '0;
   end

   assign ch_enable = run_q;

endmodule

// File: rtl/pwm_rf_chk.sv
module pwm_rf_chk #(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic              wr,
   input logic              rd,
   input logic [DATA_W-1:0] rdata,
   input logic [NUM_CH-1:0] evt,
   input logic [NUM_CH-1:0] run,
   input logic [NUM_CH-1:0] irq
);

   logic a_start, a_stop, a_sts, a_evt, a_zero;
   assign a_start = (32'(addr) == 32'h004);
   assign a_stop  = (32'(addr) == 32'h008);
   assign a_sts   = (32'(addr) == 32'h00C);
   assign a_evt   = (32'(addr) == 32'h01C);
   assign a_zero  = (32'(addr) == 32'h000);

   AST_START_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && a_start) |=> ((run & $past(wdata[NUM_CH-1:0])) == $past(wdata[NUM_CH-1:0]))); // R1
   AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && a_stop) |=> ((run & $past(wdata[NUM_CH-1:0])) == '0)); // R2
   AST_RUN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && (a_start || a_stop)) |=> $stable(run)); // R1
   AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && a_sts) |=> (rdata == DATA_W'($past(run)))); // R3
   AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd && a_evt) |=> ((irq & $past(irq)) == $past(irq))); // R4
   AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt) |=> ((irq & $past(evt)) == $past(evt))); // R4
   AST_EVENT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && a_evt) |=> (irq == $past(evt))); // R5
   AST_EVENT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && a_evt) |=> (rdata == DATA_W'($past(irq)))); // R5
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && a_zero) |=> (rdata == '0)); // R8
   AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> (rdata == '0)); // R9

endmodule

bind pwm_rf_top pwm_rf_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .addr  (bus_addr),
   .wdata (bus_wdata),
   .wr    (bus_wr),
   .rd    (bus_rd),
   .rdata (bus_rdata),
   .evt   (period_start),
   .run   (run_q),
   .irq   (irq_q)
);

// File: tb/sim_pwm_rf_top.sv
`timescale 1ns/1ps
module sim_pwm_rf_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic [3:0]  period_start = '0;
   logic [3:0]  ch_enable;
   logic [43:0] ch_mode;
   logic [63:0] ch_duty, ch_duty_nxt, ch_period, ch_period_nxt;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pwm_rf_top u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .period_start(period_start), .ch_enable(ch_enable), .ch_mode(ch_mode),
      .ch_duty(ch_duty), .ch_duty_nxt(ch_duty_nxt), .ch_period(ch_period),
      .ch_period_nxt(ch_period_nxt)
   );

   typedef struct packed {
      logic        rd;
      logic [11:0] a;
      logic [31:0] d;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 26;
   localparam vec_t VT [NV] = '{
      '{1'b0, 12'h200, 32'h0000_FFFF, 4'd6},  // R6 mode ch0, truncated to 11 bits
      '{1'b1, 12'h200, 32'h0000_07FF, 4'd6},
      '{1'b0, 12'h204, 32'h1234_5678, 4'd7},  // R7 duty ch0
      '{1'b1, 12'h204, 32'h0000_5678, 4'd7},
      '{1'b0, 12'h228, 32'h0000_AAAA, 4'd7},  // R7 queued duty ch1
      '{1'b1, 12'h228, 32'h0000_AAAA, 4'd7},
      '{1'b0, 12'h24C, 32'hFFFF_BEEF, 4'd7},  // R7 period ch2
      '{1'b1, 12'h24C, 32'h0000_BEEF, 4'd7},
      '{1'b0, 12'h270, 32'h0000_0C0D, 4'd7},  // R7 queued period ch3
      '{1'b1, 12'h270, 32'h0000_0C0D, 4'd7},
      '{1'b0, 12'h214, 32'h0000_0055, 4'd8},  // R8 hole inside window
      '{1'b1, 12'h214, 32'h0000_0000, 4'd8},
      '{1'b1, 12'h204, 32'h0000_5678, 4'd8},
      '{1'b0, 12'h004, 32'h0000_0005, 4'd1},  // R1 sparse start
      '{1'b1, 12'h00C, 32'h0000_0005, 4'd1},
      '{1'b0, 12'h004, 32'h0000_0000, 4'd1},  // R1 zero mask
      '{1'b1, 12'h00C, 32'h0000_0005, 4'd1},
      '{1'b0, 12'h008, 32'h0000_0001, 4'd2},  // R2 stop ch0
      '{1'b1, 12'h00C, 32'h0000_0004, 4'd2},
      '{1'b0, 12'h008, 32'h0000_0000, 4'd2},  // R2 zero mask
      '{1'b1, 12'h00C, 32'h0000_0004, 4'd2},
      '{1'b0, 12'h004, 32'hFFFF_FFFF, 4'd3},  // R3 upper bits stay zero
      '{1'b1, 12'h00C, 32'h0000_000F, 4'd3},
      '{1'b0, 12'h280, 32'h0000_0099, 4'd8},  // R8 beyond last window
      '{1'b1, 12'h280, 32'h0000_0000, 4'd8},
      '{1'b1, 12'h010, 32'h0000_0000, 4'd8}
   };

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [11:0] a, output logic [31:0] r);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      r = bus_rdata;
   endtask

   task automatic pulse(input logic [3:0] m);
      @(negedge clk);
      period_start = m;
      @(negedge clk);
      period_start = '0;
   endtask

   initial begin : watchdog
      #500000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] r;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state
      check("R10 rdata", 64'(bus_rdata), 64'h0);
      check("R10 enable", 64'(ch_enable), 64'h0);
      check("R10 period", ch_period, 64'h0);
      check("R10 mode", 64'(ch_mode), 64'h0);
      bus_read(12'h01C, r);
      check("R10 events", 64'(r), 64'h0);

      // vector table
      for (int i = 0; i < NV; i++) begin
         if (VT[i].rd) begin
            bus_read(VT[i].a, r);
            check($sformatf("R%0d vector %0d", VT[i].req, i), 64'(r), 64'(VT[i].d));
         end else begin
            bus_write(VT[i].a, VT[i].d);
         end
      end

      // R6 R7 register contents at the output buses
      check("R6 ch_mode slice0", 64'(ch_mode[10:0]), 64'h7FF);
      check("R7 ch_duty slice0", 64'(ch_duty[15:0]), 64'h5678);
      check("R7 ch_duty_nxt slice1", 64'(ch_duty_nxt[31:16]), 64'hAAAA);
      check("R7 ch_period slice2", 64'(ch_period[47:32]), 64'hBEEF);
      check("R7 ch_period_nxt slice3", 64'(ch_period_nxt[63:48]), 64'h0C0D);
      check("R8 untouched duty bus", ch_duty & 64'hFFFF_FFFF_FFFF_0000, 64'h0);
      check("R3 ch_enable", 64'(ch_enable), 64'hF);

      // R3 status is read-only
      bus_write(12'h00C, 32'h0);
      bus_read(12'h00C, r);
      check("R3 status write ignored", 64'(r), 64'hF);

      // R9 read latency and idle zero
      @(negedge clk);
      bus_addr = 12'h00C; bus_rd = 1'b1;
      #1 check("R9 not before edge", 64'(bus_rdata), 64'h0);
      @(negedge clk);
      bus_rd = 1'b0;
      check("R9 data after edge", 64'(bus_rdata), 64'hF);
      @(negedge clk);
      check("R9 idle zero", 64'(bus_rdata), 64'h0);

      // R4 latch and hold
      pulse(4'b0010);
      bus_read(12'h01C, r);
      check("R4 single event", 64'(r), 64'h2);
      bus_read(12'h01C, r);
      check("R5 cleared by read", 64'(r), 64'h0);
      pulse(4'b1000);
      repeat (10) @(negedge clk);
      bus_read(12'h01C, r);
      check("R4 held over idle", 64'(r), 64'h8);

      // R5 event coinciding with the clearing read
      pulse(4'b0100);
      @(negedge clk);
      bus_addr = 12'h01C; bus_rd = 1'b1; period_start = 4'b0001;
      @(negedge clk);
      bus_rd = 1'b0; period_start = '0;
      check("R5 read returns prior", 64'(bus_rdata), 64'h4);
      bus_read(12'h01C, r);
      check("R5 coincident event kept", 64'(r), 64'h1);

      // R2 stop all
      bus_write(12'h008, 32'hF);
      check("R2 all stopped", 64'(ch_enable), 64'h0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule